// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a clocked host and an external asynchronous static RAM of 32,768 bytes. The host hands over one request at a time over a valid/ready handshake: a 15-bit address, a write flag and, for writes, a data byte. The block then drives the memory's three active-low strobes (select, output enable, write enable) and the address lines in the order the memory needs. It returns the read byte with a one-cycle valid pulse. Every wait is counted in clock cycles, derived at elaboration from picosecond timing parameters by rounding up.

Reads select the memory and open its outputs with write enable high. The data pins are sampled only once the access time has been counted out. Writes select the memory and pull write enable low with output enable held high. The block waits one turnaround gap before it drives data, so that the memory has released the pins. It keeps the data steady for the setup window and then ends the write by raising write enable while select is still low. The data drive is dropped in that same cycle. The shared data pins are presented as separate out, out-enable and in signals for the pad ring.

Top module: `sram_seq_ctl`

## Requirements
- R1: While reset is held and just after it, memCeN, memOeN and memWeN are 1, memDqOe and rspValid are 0, and reqReady is 1.
- R2: A read holds memCeN=0, memOeN=0 and memWeN=1 for exactly RD_CYC cycles, starting the cycle after acceptance. In the following cycle rspValid is 1 for one cycle, rspData carries the byte on memDqIn at the end of the last read cycle, and memCeN is back to 1.
- R3: While memWeN is 0, memCeN is 0 and memOeN is 1. A write holds memWeN low for TURN_CYC + DRIVE_CYC cycles.
- R4: During a write memDqOe stays 0 for the first TURN_CYC cycles of the write-enable pulse and is then 1 for exactly DRIVE_CYC cycles, with memDqOut equal to the accepted write byte.
- R5: A write ends on write enable: memWeN and memDqOe return to 1 and 0 in the same cycle while memCeN stays 0 for one more cycle, and only then does memCeN return to 1.
- R6: memDqOe is never 1 in a cycle where memOeN is 0.
- R7: memAddr equals the accepted address and holds steady in every cycle that memCeN is 0.
- R8: reqReady is 1 only while no operation is in progress. A request offered in the cycle reqReady returns is accepted, and its strobes start in the next cycle, with no idle gap between operations beyond that cycle.
- R9: The wait counts are ceil(ps / CLK_PS) with a floor of 1: RD_CYC from ACCESS_PS and TURN_CYC from TURN_PS. DRIVE_CYC is the larger of the setup count and the pulse-width count minus TURN_CYC. The defaults give 4, 2 and 2.
- R10: rspValid is never 1 on two consecutive cycles and is never raised by a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host offers a request |
| reqReady | output | 1 | Block can accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | DATA_W | Byte to write |
| rspValid | output | 1 | One-cycle pulse: read byte valid |
| rspData | output | DATA_W | Read byte |
| memAddr | output | ADDR_W | Memory address lines |
| memCeN | output | 1 | Memory select, active low |
| memOeN | output | 1 | Memory output enable, active low |
| memWeN | output | 1 | Memory write enable, active low |
| memDqOut | output | DATA_W | Byte driven toward the data pins |
| memDqOe | output | 1 | Drive enable for the data pins |
| memDqIn | input | DATA_W | Byte seen on the data pins |

## Verification
The properties assume a reset of at least one cycle before the first request, and wait parameters that all come out at one cycle or more. They take no notice of reqValid outside the idle state, because the block latches a request only when it is accepted. The stimulus changes host inputs only on the falling clock edge and raises reqValid only while reqReady is high, dropping it right after acceptance. The bench's memory model returns a poison byte until the access time has elapsed. It commits a write only on a write-enable rise that follows a driven data window.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  // Strobe bundle from the sequencer to the datapath.
  typedef struct packed {
    logic ceN;      // memory select, active low
    logic oeN;      // memory output enable, active low
    logic weN;      // memory write enable, active low
    logic drive;    // put write byte on the data pins
    logic load;     // latch a newly accepted request
    logic capture;  // sample the data pins this cycle
  } strobe_t;

  // Round a picosecond time up to whole clock cycles, never below one.
  function automatic int waitCycles(input int ps, input int clkPs);
    int c;
    c = (ps + clkPs - 1) / clkPs;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_seq_pkg::*;
#(
  parameter int RD_CYC    = 4,
  parameter int TURN_CYC  = 2,
  parameter int DRIVE_CYC = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output strobe_t st
);

  localparam int MAX_A  = (RD_CYC > TURN_CYC) ? RD_CYC : TURN_CYC;
  localparam int MAX_C  = (MAX_A > DRIVE_CYC) ? MAX_A : DRIVE_CYC;
  localparam int CNT_W  = $clog2(MAX_C + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_READ, S_TURN, S_DRIVE, S_END
  } state_t;

  state_t stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD;
  logic lastRd, lastTurn, lastDrive;

  assign lastRd    = (cntQ == CNT_W'(RD_CYC - 1));
  assign lastTurn  = (cntQ == CNT_W'(TURN_CYC - 1));
  assign lastDrive = (cntQ == CNT_W'(DRIVE_CYC - 1));

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      S_IDLE:  if (reqValid) stateD = reqWrite ? S_TURN : S_READ;
      S_READ:  if (lastRd) stateD = S_IDLE;
      S_TURN:  if (lastTurn) stateD = S_DRIVE;
      S_DRIVE: if (lastDrive) stateD = S_END;
      S_END:   stateD = S_IDLE;
      default: stateD = S_IDLE;
    endcase
    cntD = (stateD != stateQ) ? '0 : cntQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      cntQ   <= '0;
    end else begin
      stateQ <= stateD;
      cntQ   <= cntD;
    end
  end

  // Strobe decode: write enable ends the write, select lingers one cycle.
  always_comb begin
    st = '{ceN: 1'b1, oeN: 1'b1, weN: 1'b1, drive: 1'b0, load: 1'b0, capture: 1'b0};
    unique case (stateQ)
      S_IDLE:  st.load = reqValid;
      S_READ:  begin st.ceN = 1'b0; st.oeN = 1'b0; st.capture = lastRd; end
      S_TURN:  begin st.ceN = 1'b0; st.weN = 1'b0; end
      S_DRIVE: begin st.ceN = 1'b0; st.weN = 1'b0; st.drive = 1'b1; end
      S_END:   st.ceN = 1'b0;
      default: ;
    endcase
  end

  assign reqReady = (stateQ == S_IDLE);

endmodule

// File: rtl/sram_seq_dp.sv
module sram_seq_dp
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ, rdataQ;
  logic              rspValidQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ     <= '0;
      wdataQ    <= '0;
      rdataQ    <= '0;
      rspValidQ <= 1'b0;
    end else begin
      if (st.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (st.capture) rdataQ <= memDqIn;
      rspValidQ <= st.capture;
    end
  end

  assign memAddr  = addrQ;
  assign memDqOut = wdataQ;
  assign memDqOe  = st.drive;
  assign memCeN   = st.ceN;
  assign memOeN   = st.oeN;
  assign memWeN   = st.weN;
  assign rspValid = rspValidQ;
  assign rspData  = rdataQ;

endmodule

// File: rtl/sram_seq_ctl.sv
module sram_seq_ctl
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 8,
  parameter int CLK_PS     = 10000,
  parameter int ACCESS_PS  = 35000,
  parameter int TURN_PS    = 15000,
  parameter int SETUP_PS   = 15000,
  parameter int PULSE_PS   = 22000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  localparam int RD_CYC    = waitCycles(ACCESS_PS, CLK_PS);
  localparam int TURN_CYC  = waitCycles(TURN_PS, CLK_PS);
  localparam int SETUP_CYC = waitCycles(SETUP_PS, CLK_PS);
  localparam int PWE_CYC   = waitCycles(PULSE_PS, CLK_PS);
  localparam int PWE_REST  = (PWE_CYC > TURN_CYC) ? PWE_CYC - TURN_CYC : 1;
  localparam int DRIVE_CYC = (SETUP_CYC > PWE_REST) ? SETUP_CYC : PWE_REST;

  strobe_t st;

  sram_seq_fsm #(
    .RD_CYC(RD_CYC), .TURN_CYC(TURN_CYC), .DRIVE_CYC(DRIVE_CYC)
  ) u_fsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .st(st)
  );

  sram_seq_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .memDqIn(memDqIn), .memAddr(memAddr), .memDqOut(memDqOut),
    .memDqOe(memDqOe), .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN),
    .rspValid(rspValid), .rspData(rspData)
  );

endmodule

// File: rtl/sram_seq_chk.sv
module sram_seq_chk #(
  parameter int ADDR_W    = 15,
  parameter int DRIVE_CYC = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rspValid,
  input logic              memCeN,
  input logic              memOeN,
  input logic              memWeN,
  input logic              memDqOe,
  input logic [ADDR_W-1:0] memAddr
);

  localparam int DC_W = $clog2(DRIVE_CYC + 2);
  logic [DC_W-1:0] drvCnt;

  always_ff @(posedge clk) begin
    if (!rstN) drvCnt <= '0;
    else if (memDqOe) drvCnt <= drvCnt + 1'b1;
    else drvCnt <= '0;
  end

  // R6
  no_contention_chk: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> memOeN);

  // R3
  we_needs_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (!memCeN && memOeN));

  // R5
  we_ends_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (!memCeN && $fell(memDqOe)));

  // R4
  drive_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memDqOe) |-> (drvCnt == DC_W'(DRIVE_CYC)));

  // R7
  addr_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && $past(!memCeN)) |-> $stable(memAddr));

  // R10
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R2
  rsp_deselected_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (memCeN && reqReady));

  // R8
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memCeN |-> !reqReady);

endmodule

bind sram_seq_ctl sram_seq_chk #(.ADDR_W(ADDR_W), .DRIVE_CYC(DRIVE_CYC)) u_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .rspValid(rspValid),
  .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN), .memDqOe(memDqOe),
  .memAddr(memAddr)
);

// File: tb/sim_sram_seq_ctl.sv
module sim_sram_seq_ctl;

  localparam int AW = 15;
  localparam int DW = 8;
  localparam int CLK_PS = 10000;

  // R9: expected wait counts, rounded up from picoseconds by the bench itself
  function automatic int ceilCyc(input int ps);
    int c;
    c = ps / CLK_PS;
    if (c * CLK_PS < ps) c++;
    if (c < 1) c = 1;
    return c;
  endfunction
  localparam int EXP_RD    = ceilCyc(35000);
  localparam int EXP_TURN  = ceilCyc(15000);
  localparam int EXP_DRIVE = (ceilCyc(15000) > ceilCyc(22000) - EXP_TURN)
                             ? ceilCyc(15000) : ceilCyc(22000) - EXP_TURN;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic reqReady, rspValid, memCeN, memOeN, memWeN, memDqOe;
  logic [DW-1:0] rspData, memDqOut, memDqIn;
  logic [AW-1:0] memAddr;

  int checks = 0;
  int errors = 0;

  always #5ns clk = ~clk;

  sram_seq_ctl #(
    .ADDR_W(AW), .DATA_W(DW), .CLK_PS(CLK_PS), .ACCESS_PS(35000),
    .TURN_PS(15000), .SETUP_PS(15000), .PULSE_PS(22000)
  ) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .memAddr(memAddr),
    .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  // ---------------- memory model ----------------
  logic [DW-1:0] memArr [logic [AW-1:0]];
  logic [DW-1:0] shadow [logic [AW-1:0]];
  int readAge = 0;
  logic prevWe = 1'b1;
  logic [DW-1:0] pend = '0;
  logic pendOk = 1'b0;

  function automatic logic [DW-1:0] initPat(input logic [AW-1:0] a);
    return a[7:0] ^ 8'h3C;
  endfunction

  always_comb begin
    memDqIn = 8'hA5;  // poison until the access time has elapsed
    if (!memCeN && !memOeN && memWeN && readAge >= EXP_RD - 1)
      memDqIn = memArr.exists(memAddr) ? memArr[memAddr] : initPat(memAddr);
  end

  always @(posedge clk) begin
    readAge <= (!memCeN && !memOeN && memWeN) ? readAge + 1 : 0;
    prevWe  <= memWeN;
    if (!memCeN && !memWeN && memDqOe) begin
      pend   <= memDqOut;
      pendOk <= 1'b1;
    end
    if (!memCeN && memWeN && !prevWe && pendOk) begin
      memArr[memAddr] = pend;
      pendOk <= 1'b0;
    end
  end

  // ---------------- checking helpers ----------------
  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic expPins(input logic ce, input logic oe, input logic we,
                         input logic drv, input logic rdy, input string req);
    logic [4:0] act, exp;
    act = {memCeN, memOeN, memWeN, memDqOe, reqReady};
    exp = {ce, oe, we, drv, rdy};
    check(act == exp, req, "{ce,oe,we,drive,ready}", int'(act), int'(exp));
  endtask

  logic [DW-1:0] expQ [$];

  // ---------------- driver ----------------
  task automatic doWrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    check(reqReady == 1'b1, "R8", "ready before request", int'(reqReady), 1);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0; reqAddr = ~a; reqWdata = ~d;
    for (int i = 0; i < EXP_TURN; i++) begin
      expPins(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R3");
      check(memAddr == a, "R7", "write address", int'(memAddr), int'(a));
      @(negedge clk);
    end
    for (int i = 0; i < EXP_DRIVE; i++) begin
      expPins(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R4");
      check(memDqOut == d, "R4", "driven byte", int'(memDqOut), int'(d));
      @(negedge clk);
    end
    expPins(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R5");
    check(memAddr == a, "R7", "address at write end", int'(memAddr), int'(a));
    @(negedge clk);
    expPins(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R5");
    check(rspValid == 1'b0, "R10", "no response for write", int'(rspValid), 0);
    shadow[a] = d;
  endtask

  task automatic doRead(input logic [AW-1:0] a);
    check(reqReady == 1'b1, "R8", "ready before request", int'(reqReady), 1);
    expQ.push_back(shadow.exists(a) ? shadow[a] : initPat(a));
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0; reqAddr = ~a;
    for (int i = 0; i < EXP_RD; i++) begin
      expPins(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R2");
      check(memAddr == a, "R7", "read address", int'(memAddr), int'(a));
      @(negedge clk);
    end
    // R9: select released exactly after the rounded access count
    expPins(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R9");
  endtask

  // ---------------- monitor / scoreboard ----------------
  logic prevRsp = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      check(!(memDqOe && !memOeN), "R6", "drive while output enabled",
            int'(memDqOe), 0);
      if (rspValid) begin
        check(!prevRsp, "R10", "back-to-back response", int'(prevRsp), 0);
        if (expQ.size() == 0) begin
          check(1'b0, "R10", "unexpected response", int'(rspData), 0);
        end else begin
          logic [DW-1:0] e;
          e = expQ.pop_front();
          check(rspData == e, "R2", "read byte", int'(rspData), int'(e));
        end
      end
      prevRsp = rspValid;
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // ---------------- sequence ----------------
  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    expPins(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R1");
    check(rspValid == 1'b0, "R1", "rspValid in reset", int'(rspValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    expPins(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R1");

    doRead(15'h0123);              // unwritten location
    doWrite(15'h0000, 8'h5A);      // lowest address
    doWrite(15'h7FFF, 8'hC3);      // highest address
    doRead(15'h0000);
    doRead(15'h7FFF);              // back-to-back reads (R8)
    doWrite(15'h1234, 8'hFF);
    doWrite(15'h1234, 8'h00);      // overwrite, back-to-back writes
    doRead(15'h1234);
    doWrite(15'h2AAA, 8'hA5);      // write right after read
    doRead(15'h2AAA);
    for (int i = 0; i < 6; i++) begin
      doWrite(15'(i * 1111 + 7), 8'(i * 37 + 1));
      doRead(15'(i * 1111 + 7));
    end
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R2", "responses outstanding", expQ.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule